// File: doc/BRIEF.md
# 64-bit Extension Request Generator

This block decides, for each transaction a bus master starts, whether the master may ask for the 64-bit data extension. It then drives the active-low 64-bit request pin. The master's sequencer gives a one-cycle start pulse in the cycle before the address phase. With that pulse come the command class, the two low quadword address bits, the number of Dwords waiting in the posted write buffer, a single-Dword flag and a flag that marks the transaction as a resumed write. The block checks every inhibit rule against these registered inputs and stores a single decision bit. After that, the request pin follows the master's frame signal for as long as the decision holds.

The block also keeps two pieces of history. The first is whether the bus can carry 64-bit transfers at all, which is read from the request pin while reset is held. The second is whether the last target acknowledged a 64-bit transfer, which is captured at each target termination. A write that resumes after a disconnect uses this acknowledgement history. A retry does not overwrite it.

Top module: `req64_gen`

## Requirements
- R1: `req64_no` is low only while `frame_ni` is low. While `frame_ni` stays low, `req64_no` does not change. When `frame_ni` rises, `req64_no` rises in the same cycle.
- R2: The bus capability is taken from `req64_strap_ni` during reset and on the first clock edge after release (low = capable). If it was high, `req64_no` never goes low. Changes on `req64_strap_ni` after that have no effect.
- R3: `cmd_i` encodes 0 = I/O, 1 = configuration, 2 = special cycle, 3 = non-prefetchable memory read, 4 = prefetchable memory read, 5 = memory write, 6 and 7 = reserved. Only codes 4 and 5 can request the extension.
- R4: When `qw_addr_i[0]` (address bit 2) is 1, no request is made.
- R5: A memory write with `wr_dw_i` below `MIN_WR_DW` (default 4, so three or fewer Dwords) makes no request.
- R6: A termination with `term_i`=1 and `term_retry_i`=0 stores the acknowledgement history as 1 if `ack64_ni` was low and 0 otherwise. A memory write started with `resume_i`=1 makes no request when the stored history is 0.
- R7: A termination flagged as a retry leaves the acknowledgement history unchanged.
- R8: A prefetchable read with `single_dw_i`=1 makes no request.
- R9: A prefetchable read with `qw_addr_i[1]` (address bit 3) set makes no request.
- R10: During reset `req64_no` is high. When no rule above inhibits the request, `req64_no` goes low with `frame_ni`.
- R11: A start with `resume_i`=0 clears the acknowledgement history. A resumed write that follows without any termination in between therefore makes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req64_strap_ni | input | 1 | Request pin level seen during reset, low = bus capable |
| start_i | input | 1 | One-cycle pulse before the address phase |
| cmd_i | input | 3 | Command class code |
| qw_addr_i | input | 2 | Address bits 3:2 |
| wr_dw_i | input | CNT_W | Dwords waiting in the posted write buffer |
| single_dw_i | input | 1 | Read is a single Dword |
| resume_i | input | 1 | Transaction resumes a disconnected write |
| frame_ni | input | 1 | Master frame signal, active low |
| term_i | input | 1 | Target termination seen this cycle |
| term_retry_i | input | 1 | That termination was a retry |
| ack64_ni | input | 1 | Target 64-bit acknowledge, active low |
| req64_no | output | 1 | 64-bit request, active low |

## Verification
A stored decision that is wrong shows up on `req64_no` in the first cycle `frame_ni` goes low, which is the cycle after the start pulse. A capability bit that is wrong shows up in every frame after reset. A wrong acknowledgement history stays hidden until the next resumed write. For that reason the bench loads each history value just before every resumed write, and it checks separately that a retry keeps the history and that a non-resumed start clears it. A fault that breaks the frame coupling shows up at the frame edges, so the bench samples both the first and the last low cycle of each frame and the cycle after the frame rises.

// File: rtl/req64_pkg.sv
package req64_pkg;
  typedef enum logic [2:0] {
    CMD_IO     = 3'd0,
    CMD_CFG    = 3'd1,
    CMD_SPC    = 3'd2,
    CMD_RD_NP  = 3'd3,
    CMD_RD_PF  = 3'd4,
    CMD_WR     = 3'd5,
    CMD_RSV6   = 3'd6,
    CMD_RSV7   = 3'd7
  } cmd_e;
endpackage

// File: rtl/req64_cap.sv
module req64_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_ni,
  output logic cap_o
);
  logic armed_q;
  logic cap_q;

  // armed during reset and for the edge that ends it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (armed_q) cap_q <= ~strap_ni;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/req64_hist.sv
module req64_hist (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic resume_i,
  input  logic term_i,
  input  logic term_retry_i,
  input  logic ack64_ni,
  output logic hist_o
);
  logic hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 1'b0;
    end else if (term_i && !term_retry_i) begin
      hist_q <= ~ack64_ni;
    end else if (start_i && !resume_i) begin
      hist_q <= 1'b0;
    end
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/req64_qual.sv
module req64_qual
  import req64_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int MIN_WR_DW = 4
) (
  input  logic             cap_i,
  input  cmd_e             cmd_i,
  input  logic [1:0]       qw_addr_i,
  input  logic [CNT_W-1:0] wr_dw_i,
  input  logic             single_dw_i,
  input  logic             resume_i,
  input  logic             hist_i,
  output logic             go_o
);
  localparam logic [CNT_W-1:0] MinDw = CNT_W'(MIN_WR_DW);

  logic class_ok;
  logic rule_ok;

  always_comb begin
    class_ok = 1'b0;
    rule_ok  = 1'b1;
    unique case (cmd_i)
      CMD_RD_PF: begin
        class_ok = 1'b1;
        if (single_dw_i || qw_addr_i[1]) rule_ok = 1'b0;
      end
      CMD_WR: begin
        class_ok = 1'b1;
        if (wr_dw_i < MinDw)        rule_ok = 1'b0;
        if (resume_i && !hist_i)    rule_ok = 1'b0;
      end
      default: class_ok = 1'b0;
    endcase
  end

  assign go_o = cap_i && class_ok && rule_ok && !qw_addr_i[0];
endmodule

// File: rtl/req64_gen.sv
module req64_gen
  import req64_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int MIN_WR_DW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req64_strap_ni,
  input  logic             start_i,
  input  logic [2:0]       cmd_i,
  input  logic [1:0]       qw_addr_i,
  input  logic [CNT_W-1:0] wr_dw_i,
  input  logic             single_dw_i,
  input  logic             resume_i,
  input  logic             frame_ni,
  input  logic             term_i,
  input  logic             term_retry_i,
  input  logic             ack64_ni,
  output logic             req64_no
);
  logic cap_q;
  logic hist_q;
  logic go_d;
  logic dec_q;

  req64_cap u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_ni (req64_strap_ni),
    .cap_o    (cap_q)
  );

  req64_hist u_hist (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .resume_i     (resume_i),
    .term_i       (term_i),
    .term_retry_i (term_retry_i),
    .ack64_ni     (ack64_ni),
    .hist_o       (hist_q)
  );

  req64_qual #(
    .CNT_W     (CNT_W),
    .MIN_WR_DW (MIN_WR_DW)
  ) u_qual (
    .cap_i       (cap_q),
    .cmd_i       (cmd_e'(cmd_i)),
    .qw_addr_i   (qw_addr_i),
    .wr_dw_i     (wr_dw_i),
    .single_dw_i (single_dw_i),
    .resume_i    (resume_i),
    .hist_i      (hist_q),
    .go_o        (go_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dec_q <= 1'b0;
    else if (start_i) dec_q <= go_d;
  end

  // request tracks frame with no register in between
  assign req64_no = frame_ni | ~dec_q;
endmodule

// File: rtl/req64_chk.sv
module req64_chk #(
  parameter int CNT_W     = 4,
  parameter int MIN_WR_DW = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       cmd_i,
  input logic [1:0]       qw_addr_i,
  input logic [CNT_W-1:0] wr_dw_i,
  input logic             single_dw_i,
  input logic             resume_i,
  input logic             frame_ni,
  input logic             term_i,
  input logic             term_retry_i,
  input logic             ack64_ni,
  input logic             req64_no,
  input logic             cap_q,
  input logic             hist_q,
  input logic             dec_q
);
  localparam logic [CNT_W-1:0] MinDw = CNT_W'(MIN_WR_DW);

  assert_req_inside_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req64_no |-> !frame_ni);
  assert_req_stable_in_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_ni && $past(!frame_ni) && !$past(start_i)) |-> $stable(req64_no));
  assert_no_cap_no_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_q |-> req64_no);
  assert_cmd_class_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(cmd_i == 3'd4 || cmd_i == 3'd5)) |=> !dec_q);
  assert_qw_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && qw_addr_i[0]) |=> !dec_q);
  assert_short_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cmd_i == 3'd5 && wr_dw_i < MinDw) |=> !dec_q);
  assert_hist_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !term_retry_i) |=> hist_q == !$past(ack64_ni));
  assert_retry_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && term_retry_i && !start_i) |=> $stable(hist_q));
  assert_single_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cmd_i == 3'd4 && single_dw_i) |=> !dec_q);
  assert_line_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cmd_i == 3'd4 && qw_addr_i[1]) |=> !dec_q);
  assert_fresh_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !resume_i && !term_i) |=> !hist_q);
endmodule

bind req64_gen req64_chk #(
  .CNT_W     (CNT_W),
  .MIN_WR_DW (MIN_WR_DW)
) i_req64_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .cmd_i        (cmd_i),
  .qw_addr_i    (qw_addr_i),
  .wr_dw_i      (wr_dw_i),
  .single_dw_i  (single_dw_i),
  .resume_i     (resume_i),
  .frame_ni     (frame_ni),
  .term_i       (term_i),
  .term_retry_i (term_retry_i),
  .ack64_ni     (ack64_ni),
  .req64_no     (req64_no),
  .cap_q        (cap_q),
  .hist_q       (hist_q),
  .dec_q        (dec_q)
);

// File: tb/test_req64_gen.sv
`timescale 1ns/1ps
module test_req64_gen;
  localparam int CNT_W     = 4;
  localparam int MIN_WR_DW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req64_strap_ni = 1'b1;
  logic start_i = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [1:0] qw_addr_i = '0;
  logic [CNT_W-1:0] wr_dw_i = '0;
  logic single_dw_i = 1'b0;
  logic resume_i = 1'b0;
  logic frame_ni = 1'b1;
  logic term_i = 1'b0;
  logic term_retry_i = 1'b0;
  logic ack64_ni = 1'b1;
  logic req64_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  req64_gen #(.CNT_W(CNT_W), .MIN_WR_DW(MIN_WR_DW)) i_req64_gen (
    .clk_i(clk), .rst_ni(rst_ni), .req64_strap_ni(req64_strap_ni),
    .start_i(start_i), .cmd_i(cmd_i), .qw_addr_i(qw_addr_i), .wr_dw_i(wr_dw_i),
    .single_dw_i(single_dw_i), .resume_i(resume_i), .frame_ni(frame_ni),
    .term_i(term_i), .term_retry_i(term_retry_i), .ack64_ni(ack64_ni),
    .req64_no(req64_no)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s req64_no act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model_go(input bit cap, input int c, input int a,
                                    input int dw, input bit s, input bit r, input bit h);
    if (!cap) return 1'b0;
    if (c != 4 && c != 5) return 1'b0;
    if (a[0]) return 1'b0;
    if (c == 4 && (s || a[1])) return 1'b0;
    if (c == 5 && (dw < MIN_WR_DW || (r && !h))) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string model_tag(input bit cap, input int c, input int a,
                                      input int dw, input bit s, input bit r, input bit h);
    if (!cap) return "R2";
    if (c != 4 && c != 5) return "R3";
    if (a[0]) return "R4";
    if (c == 4 && s) return "R8";
    if (c == 4 && a[1]) return "R9";
    if (c == 5 && dw < MIN_WR_DW) return "R5";
    if (c == 5 && r && !h) return "R6";
    return "R10";
  endfunction

  task automatic do_reset(input bit cap);
    rst_ni = 1'b0;
    req64_strap_ni = ~cap;
    frame_ni = 1'b0;
    repeat (3) tick();
    chk("R10", req64_no, 1'b1);
    frame_ni = 1'b1;
    rst_ni = 1'b1;
    tick(); tick();
    req64_strap_ni = cap; // flipped after sampling window: must be ignored (R2)
  endtask

  task automatic set_hist(input bit h);
    term_i = 1'b1; term_retry_i = 1'b0; ack64_ni = ~h;
    tick();
    term_i = 1'b0; ack64_ni = 1'b1;
  endtask

  task automatic retry_term(input bit ack);
    term_i = 1'b1; term_retry_i = 1'b1; ack64_ni = ~ack;
    tick();
    term_i = 1'b0; term_retry_i = 1'b0; ack64_ni = 1'b1;
  endtask

  task automatic start_txn(input int c, input int a, input int dw, input bit s, input bit r);
    start_i = 1'b1; cmd_i = 3'(c); qw_addr_i = 2'(a); wr_dw_i = CNT_W'(dw);
    single_dw_i = s; resume_i = r;
    tick();
    start_i = 1'b0; resume_i = 1'b0; single_dw_i = 1'b0;
  endtask

  task automatic frame_check(input string tag, input logic exp_go);
    frame_ni = 1'b0; #1;
    chk(tag, req64_no, ~exp_go);           // R1: same cycle as frame fall
    tick();
    chk("R1", req64_no, ~exp_go);
    frame_ni = 1'b1; #1;
    chk("R1", req64_no, 1'b1);             // R1: released with frame
    tick();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int cap = 0; cap < 2; cap++) begin
      do_reset(cap[0]);
      for (int c = 0; c < 8; c++)
        for (int a = 0; a < 4; a++)
          for (int dw = 0; dw < (1 << CNT_W); dw++)
            for (int s = 0; s < 2; s++)
              for (int r = 0; r < 2; r++)
                for (int h = 0; h < 2; h++) begin
                  set_hist(h[0]);
                  start_txn(c, a, dw, s[0], r[0]);
                  frame_check(model_tag(cap[0], c, a, dw, s[0], r[0], h[0]),
                              model_go(cap[0], c, a, dw, s[0], r[0], h[0]));
                end
    end

    // R7: retry does not overwrite history
    do_reset(1'b1);
    set_hist(1'b1); retry_term(1'b0);
    start_txn(5, 0, 8, 1'b0, 1'b1);
    frame_check("R7", 1'b1);
    set_hist(1'b0); retry_term(1'b1);
    start_txn(5, 0, 8, 1'b0, 1'b1);
    frame_check("R7", 1'b0);

    // R11: a fresh start clears history before a resumed write
    set_hist(1'b1);
    start_txn(4, 0, 0, 1'b0, 1'b0);
    start_txn(5, 0, 8, 1'b0, 1'b1);
    frame_check("R11", 1'b0);

    // R6: history from a non-retry termination survives a resumed read start
    set_hist(1'b1);
    start_txn(4, 0, 0, 1'b0, 1'b1);
    start_txn(5, 0, 8, 1'b0, 1'b1);
    frame_check("R6", 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule